// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Generator

This block produces the switching commands for a single-phase inverter built from two H-bridge cells and one bidirectional switch tied to the midpoint of a split DC link. It reads magnitudes from a quarter-wave sine table to form a full-wave rectified reference. That reference is scaled by a modulation index and compared against four triangular carriers. The carriers share frequency and phase and sit one above the other, each in its own quarter of full scale. The number of carriers the reference lies above gives the magnitude of the output voltage level, in units of half the cell DC voltage. The sign of the unrectified sine sets the sign of that level.

The signed level is then turned into gate enables through a fixed table. The left legs of the two cells and the midpoint switch move at the carrier rate. The right legs only follow the polarity, so they switch at the fundamental rate. As the modulation index rises through each quarter of full scale, one more carrier comes into use: one carrier gives three output levels, and all four give nine. A new modulation index only takes effect at a half-cycle boundary of the reference.

Top module: `lspwm_gen`

## Requirements
- R1: After reset, `gates` is all zero and `level` is 0 until the first carrier valley. That valley occurs 128 enabled clocks after reset is released.
- R2: The base carrier rises from 0 to 1024 and falls back in steps of 16 per enabled clock, giving a 128-clock period. Carrier k (k = 0..3) equals the base carrier plus k*1024. The level magnitude is the number of carriers strictly below the scaled reference floor(sine_magnitude * index / 1024).
- R3: `polarity` is 1 during the first half of each reference period and 0 during the second half. `polarityN` is always its complement.
- R4: `level` is the carrier count when `polarity` is 1 and the negated count when it is 0.
- R5: The reference period is 5120 enabled clocks, which is 40 carrier periods. The sine magnitude at table index i is round(4095*sin(pi*(i+0.5)/512)). The index is mirrored in the second and fourth quarters of the period.
- R6: With an index of 256 or less, the level magnitude never exceeds 1. With an index of 512 or less, it never exceeds 2.
- R7: With an index of 1000, all nine levels from -4 to +4 occur within one reference period, and the peak magnitude is 4.
- R8: Gate layout: bits [3:0] belong to cell A and bits [7:4] to cell B, each ordered {low-right, high-right, low-left, high-left}; bit 8 is the midpoint switch. The magnitude splits into cell A and cell B parts as 0→(0,0), 1→(1,0), 2→(2,0), 3→(1,2), 4→(2,2). For positive polarity a cell word is 1001 for part 2, 1000 for part 1 and 1010 for part 0. For negative polarity the words are 0110, 0100 and 0101. Bit 8 is set exactly when cell A's part is 1.
- R9: High and low switches of the same leg are never on together, and the midpoint switch is on only for odd level magnitudes.
- R10: While running, the right-leg bits of both cells change only in a cycle where `polarity` changes.
- R11: `modIndex` is sampled only on the phase step that begins a half-period (phase modulo 512 becomes 0). A change at any other time has no effect on `level` or `gates` until then. The index is 0 after reset.
- R12: While `en` is 0, `gates` is 0 and `level` is 0, and the carrier, phase and prescaler hold their values. Operation resumes from the held state when `en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low freezes timing and blanks the gates |
| modIndex | input | 10 | Modulation index as an unsigned fraction of 1024 |
| gates | output | 9 | Gate enables for the two cells and the midpoint switch |
| polarity | output | 1 | High during the positive half of the reference |
| polarityN | output | 1 | Complement of polarity |
| level | output | 4 | Signed output voltage level, -4 to +4 |

## Verification
The sampling of a new modulation index and the polarity reversal both fall on the same phase step. In that one cycle the scaled reference, the carrier count and the sign all change together. The bench provokes this by writing a new index a quarter of the way into a half-period. It then compares every cycle against an independent model up to and past the boundary. Levels must still follow the old index right up to the boundary, and the new index must apply together with the new sign in the same cycle. A second coincidence, the arming valley landing on a carrier count change, is judged by checking the cycle just before the valley and the valley cycle itself.

// File: rtl/lspwm_pkg.sv
`timescale 1ns/1ps
package lspwm_pkg;
  parameter int AMP_W   = 12;  // sine magnitude and carrier span width
  parameter int ADDR_W  = 8;   // quarter-wave table address width
  parameter int MI_W    = 10;  // modulation index fraction width
  parameter int NCAR    = 4;   // number of stacked carriers
  parameter int CAR_LOG = 6;   // log2 of carrier half-period in clocks

  localparam int PH_W     = ADDR_W + 2;
  localparam int CAR_TOP  = 2 ** CAR_LOG;
  localparam int BAND     = (2 ** AMP_W) / NCAR;
  localparam int CAR_STEP = BAND / CAR_TOP;
  localparam int CNT_W    = $clog2(NCAR + 1);
  localparam int LVL_W    = CNT_W + 1;
  localparam int CELL_W   = 4;
  localparam int GATE_W   = 2 * CELL_W + 1;

  typedef struct packed {
    logic                run;     // armed and enabled
    logic [CAR_LOG:0]    carPos;  // base carrier position 0..CAR_TOP
    logic [PH_W-1:0]     phase;   // reference phase
    logic [MI_W-1:0]     modIdx;  // latched modulation index
  } ctrl_t;
endpackage

// File: rtl/lspwm_ctrl.sv
`timescale 1ns/1ps
module lspwm_ctrl
  import lspwm_pkg::*;
#(
  parameter int PRESCALE = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [MI_W-1:0] modIndex,
  output ctrl_t           ctl
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CAR_LOG:0] CAR_LAST = (CAR_LOG + 1)'(CAR_TOP - 1);
  localparam logic [CAR_LOG:0] CAR_ONE  = (CAR_LOG + 1)'(1);
  localparam logic [CAR_LOG:0] CAR_MAX  = (CAR_LOG + 1)'(CAR_TOP);

  logic [CAR_LOG:0]  carPos;
  logic              carUp;
  logic              armed;
  logic [PRE_W-1:0]  preCnt;
  logic [PH_W-1:0]   phase;
  logic [MI_W-1:0]   miReg;
  logic              preWrap;
  logic [PH_W-1:0]   phaseNext;
  logic              halfBoundary;

  always_comb begin
    preWrap      = (preCnt == PRE_W'(PRESCALE - 1));
    phaseNext    = phase + 1'b1;
    halfBoundary = preWrap && (phaseNext[PH_W-2:0] == '0);
  end

  // carrier triangle and arming at the first valley
  always_ff @(posedge clk) begin
    if (rst) begin
      carPos <= '0;
      carUp  <= 1'b1;
      armed  <= 1'b0;
    end else if (en) begin
      if (carUp) begin
        carPos <= carPos + 1'b1;
        if (carPos == CAR_LAST) carUp <= 1'b0;
      end else begin
        carPos <= carPos - 1'b1;
        if (carPos == CAR_ONE) begin
          carUp <= 1'b1;
          armed <= 1'b1;
        end
      end
    end
  end

  // phase accumulator with prescaler, index latch at half-period start
  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      phase  <= '0;
      miReg  <= '0;
    end else if (en) begin
      if (preWrap) begin
        preCnt <= '0;
        phase  <= phaseNext;
        if (halfBoundary) miReg <= modIndex;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.run    = en && armed;
    ctl.carPos = carPos;
    ctl.phase  = phase;
    ctl.modIdx = miReg;
  end

  p_carrier_range_r2: assert property (@(posedge clk) disable iff (rst)
    carPos <= CAR_MAX);

  p_arm_at_valley_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> (carPos == '0));

  p_mi_hold_r11: assert property (@(posedge clk) disable iff (rst)
    $changed(miReg) |-> (phase[PH_W-2:0] == '0));

  p_freeze_r12: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(carPos) && $stable(phase)));
endmodule

// File: rtl/lspwm_dp.sv
`timescale 1ns/1ps
module lspwm_dp
  import lspwm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  ctrl_t                   ctl,
  output logic [GATE_W-1:0]       gates,
  output logic                    polarity,
  output logic                    polarityN,
  output logic signed [LVL_W-1:0] level
);
  localparam int  TAB_N   = 2 ** ADDR_W;
  localparam real AMP_MAX = real'(2 ** AMP_W - 1);
  localparam real PI_C    = 3.14159265358979;
  localparam int  CMP_W   = AMP_W + 1;
  localparam int  PROD_W  = AMP_W + MI_W;
  localparam logic [MI_W-1:0] MI_QUARTER = MI_W'((2 ** MI_W) / NCAR);

  logic [AMP_W-1:0]  sineTab [TAB_N];
  logic [ADDR_W-1:0] tabIdx;
  logic [AMP_W-1:0]  mag;
  logic [AMP_W-1:0]  refLvl;
  logic [NCAR-1:0]   above;
  logic [CNT_W-1:0]  count;
  logic [1:0]        aMag, bMag;
  logic [LVL_W-1:0]  magExt;

  // quarter-wave table computed at elaboration
  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    localparam real ANG = PI_C * (real'(i) + 0.5) / (2.0 * real'(TAB_N));
    localparam int  VAL = $rtoi(AMP_MAX * $sin(ANG) + 0.5);
    assign sineTab[i] = AMP_W'(VAL);
  end

  always_comb begin
    polarity  = ~ctl.phase[PH_W-1];
    polarityN = ctl.phase[PH_W-1];
    tabIdx    = ctl.phase[ADDR_W] ? ~ctl.phase[ADDR_W-1:0] : ctl.phase[ADDR_W-1:0];
    mag       = sineTab[tabIdx];
    refLvl    = AMP_W'((PROD_W'(mag) * PROD_W'(ctl.modIdx)) >> MI_W);
  end

  // stacked carriers and their comparators
  for (genvar k = 0; k < NCAR; k++) begin : g_car
    localparam logic [CMP_W-1:0] BASE = CMP_W'(k * BAND);
    logic [CMP_W-1:0] carVal;
    assign carVal   = BASE + CMP_W'(ctl.carPos) * CMP_W'(CAR_STEP);
    assign above[k] = {1'b0, refLvl} > carVal;
  end

  always_comb begin
    count = '0;
    for (int k = 0; k < NCAR; k++) count = count + CNT_W'(above[k]);
  end

  always_comb begin
    aMag = 2'd0;
    bMag = 2'd0;
    case (count)
      3'd1: aMag = 2'd1;
      3'd2: aMag = 2'd2;
      3'd3: begin aMag = 2'd1; bMag = 2'd2; end
      3'd4: begin aMag = 2'd2; bMag = 2'd2; end
      default: ;
    endcase
  end

  function automatic logic [CELL_W-1:0] cellWord(input logic [1:0] m, input logic pos);
    logic [CELL_W-1:0] w;
    case (m)
      2'd2:    w = pos ? 4'b1001 : 4'b0110;
      2'd1:    w = pos ? 4'b1000 : 4'b0100;
      default: w = pos ? 4'b1010 : 4'b0101;
    endcase
    return w;
  endfunction

  always_comb begin
    magExt = {1'b0, count};
    if (ctl.run) begin
      gates = {(aMag == 2'd1), cellWord(bMag, polarity), cellWord(aMag, polarity)};
      level = polarity ? signed'(magExt) : -signed'(magExt);
    end else begin
      gates = '0;
      level = '0;
    end
  end

  p_one_per_leg_r9: assert property (@(posedge clk) disable iff (rst)
    !(gates[0] && gates[1]) && !(gates[2] && gates[3]) &&
    !(gates[4] && gates[5]) && !(gates[6] && gates[7]));

  p_bidir_odd_r9: assert property (@(posedge clk) disable iff (rst)
    gates[8] == level[0]);

  p_right_steady_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.run && $past(ctl.run) && $stable(polarity)) |->
      $stable({gates[7:6], gates[3:2]}));

  p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.modIdx <= MI_QUARTER) |-> (count <= CNT_W'(1)));
endmodule

// File: rtl/lspwm_gen.sv
`timescale 1ns/1ps
module lspwm_gen
  import lspwm_pkg::*;
#(
  parameter int PRESCALE = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [MI_W-1:0]         modIndex,
  output logic [GATE_W-1:0]       gates,
  output logic                    polarity,
  output logic                    polarityN,
  output logic signed [LVL_W-1:0] level
);
  ctrl_t ctl;

  lspwm_ctrl #(.PRESCALE(PRESCALE)) i_ctrl (
    .clk(clk), .rst(rst), .en(en), .modIndex(modIndex), .ctl(ctl)
  );

  lspwm_dp i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .gates(gates),
    .polarity(polarity), .polarityN(polarityN), .level(level)
  );
endmodule

// File: tb/test_lspwm_gen.sv
`timescale 1ns/1ps
module test_lspwm_gen;
  localparam int  CLK_PERIOD = 10;
  localparam int  PRESCALE   = 5;
  localparam real PI_C       = 3.14159265358979;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic [9:0] modIndex = '0;
  logic [8:0] gates;
  logic       polarity, polarityN;
  logic signed [3:0] level;

  int checks = 0;
  int errors = 0;
  int mT, mUp, mArmed, mPre, mPh, mMi;

  lspwm_gen #(.PRESCALE(PRESCALE)) i_lspwm_gen (
    .clk(clk), .rst(rst), .en(en), .modIndex(modIndex), .gates(gates),
    .polarity(polarity), .polarityN(polarityN), .level(level)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic modelStep();
    if (rst) begin
      mT = 0; mUp = 1; mArmed = 0; mPre = 0; mPh = 0; mMi = 0;
    end else if (en) begin
      if (mUp != 0) begin
        mT++;
        if (mT == 64) mUp = 0;
      end else begin
        mT--;
        if (mT == 0) begin mUp = 1; mArmed = 1; end
      end
      if (mPre == PRESCALE - 1) begin
        mPre = 0;
        mPh = (mPh + 1) % 1024;
        if (mPh % 512 == 0) mMi = int'(modIndex);
      end else mPre++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  function automatic int expPol();
    return (mPh < 512) ? 1 : 0;
  endfunction

  function automatic int expLevel();
    int idx = mPh % 256;
    int i   = ((mPh / 256) % 2 == 1) ? 255 - idx : idx;
    int mg  = $rtoi(4095.0 * $sin(PI_C * (real'(i) + 0.5) / 512.0) + 0.5);
    int rf  = (mg * mMi) / 1024;
    int cnt = 0;
    if (!(en && mArmed != 0)) return 0;
    for (int k = 0; k < 4; k++) if (rf > k * 1024 + mT * 16) cnt++;
    return (expPol() != 0) ? cnt : -cnt;
  endfunction

  function automatic logic [3:0] cellExp(int part, int pos);
    if (pos != 0) return (part == 2) ? 4'b1001 : (part == 1) ? 4'b1000 : 4'b1010;
    return (part == 2) ? 4'b0110 : (part == 1) ? 4'b0100 : 4'b0101;
  endfunction

  function automatic logic [8:0] expGates(int lv);
    int m = (lv < 0) ? -lv : lv;
    int a = (m == 0) ? 0 : (m == 1 || m == 3) ? 1 : 2;
    int b = (m >= 3) ? 2 : 0;
    if (!(en && mArmed != 0)) return 9'h000;
    return {(a == 1) ? 1'b1 : 1'b0, cellExp(b, expPol()), cellExp(a, expPol())};
  endfunction

  task automatic checkOut(string tag);
    int el = expLevel();
    logic [8:0] eg = expGates(el);
    checks++;
    if (int'(level) != el || gates !== eg || int'(polarity) != expPol() ||
        polarityN !== ~polarity) begin
      errors++;
      $display("FAIL %s: actual level=%0d gates=%h pol=%b/%b expected level=%0d gates=%h pol=%0d",
               tag, level, gates, polarity, polarityN, el, eg, expPol());
    end
  endtask

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; modIndex = 10'd900;
    for (int c = 0; c < 3; c++) tick();
    checkVal("R1 reset gates", int'(gates), 0);
    checkVal("R1 reset level", int'(level), 0);
    checkVal("R3 reset polarity", int'(polarity), 1);
    rst = 1'b0;
    for (int c = 0; c < 127; c++) begin
      tick();
      checkOut("R1 pre-arm");
    end
    checkVal("R1 still off one cycle before valley", int'(gates), 0);
    tick();
    checkVal("R1 R8 valley arms zero-level gates", int'(gates), 9'h0AA);
    checkVal("R11 index still reset value", int'(level), 0);
  endtask

  task automatic t_sweep(int mi, int expMax, int expDistinct, string tag);
    int maxMag = 0;
    int distinct = 0;
    int rightJumps = 0;
    bit [8:0] seen = '0;
    logic [3:0] prevRight;
    logic prevPol;
    modIndex = 10'(mi);
    while (mMi != mi) begin tick(); checkOut("R2 R4 R8 pre-latch"); end
    prevRight = {gates[7:6], gates[3:2]};
    prevPol = polarity;
    for (int c = 0; c < 5120; c++) begin
      int lv;
      tick();
      checkOut("R2 R4 R8 sweep");
      lv = int'(level);
      if (lv > maxMag) maxMag = lv;
      if (-lv > maxMag) maxMag = -lv;
      seen[lv + 4] = 1'b1;
      if (polarity == prevPol && {gates[7:6], gates[3:2]} != prevRight) rightJumps++;
      prevRight = {gates[7:6], gates[3:2]};
      prevPol = polarity;
    end
    for (int j = 0; j < 9; j++) distinct += int'(seen[j]);
    checkVal({tag, " peak magnitude"}, maxMag, expMax);
    if (expDistinct > 0) checkVal("R7 nine distinct levels", distinct, expDistinct);
    checkVal("R10 right legs steady within half-cycle", rightJumps, 0);
  endtask

  task automatic t_period();
    int n = 0;
    logic prev;
    prev = polarity;
    while (!(polarity && !prev)) begin prev = polarity; tick(); end
    prev = polarity;
    do begin prev = polarity; tick(); n++; end while (!(polarity && !prev));
    checkVal("R5 reference period", n, 5120);
  endtask

  task automatic t_mid_change();
    int nonzero = 0;
    int late = 0;
    while (!(mMi == 1000 && mPh % 512 == 128)) tick();
    modIndex = 10'd0;
    while (mMi != 0) begin
      tick();
      checkOut("R11 before boundary");
      if (mMi != 0 && level != 0) nonzero++;
    end
    if (nonzero == 0) checkVal("R11 old index active before boundary", 0, 1);
    else checkVal("R11 old index active before boundary", 1, 1);
    for (int c = 0; c < 1000; c++) begin
      tick();
      checkOut("R11 after boundary");
      if (level != 0) late++;
    end
    checkVal("R11 new index applied", late, 0);
  endtask

  task automatic t_enable();
    logic holdPol;
    modIndex = 10'd1000;
    while (mMi != 1000) tick();
    repeat (300) tick();
    en = 1'b0;
    #1;
    holdPol = polarity;
    checkVal("R12 gates blank at disable", int'(gates), 0);
    for (int c = 0; c < 300; c++) begin
      tick();
      checkOut("R12 disabled");
    end
    checkVal("R12 polarity held", int'(polarity), int'(holdPol));
    en = 1'b1;
    for (int c = 0; c < 1500; c++) begin
      tick();
      checkOut("R12 resume");
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep(200, 1, 0, "R6 quarter index");
    t_sweep(450, 2, 0, "R6 half index");
    t_sweep(700, 3, 0, "R2 three carriers");
    t_sweep(1000, 4, 9, "R7 full index");
    t_period();
    t_mid_change();
    t_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule